// File: doc/BRIEF.md
# Dual-Input Decade Counter

The block holds independent 4-bit decade counters. Each channel runs on the free-running system clock and watches two asynchronous count-control lines. One line counts on its rising edge and the other on its falling edge. Each line acts as an enable for the other, so either can be used as the count clock while the other is held or driven as a gate. Both control lines pass through two-flop synchronizers. An edge is found by comparing the newest synchronized sample with the one before it.

Each channel also has an active-high clear that zeroes its outputs at once, whatever the control lines are doing. The clear release is retimed to the system clock, so edges that arrive while clear is active are discarded. Bit 3 of a channel falls when the count wraps from 9 to 0. Feeding that bit into the falling-edge input of the next channel chains the channels into a multi-digit decimal counter.

Top module: `dual_decade_counter`

## Requirements
- R1: A low-to-high change of `rise_i[c]` advances channel c by one when the previous synchronized sample of `fall_i[c]` is high.
- R2: A high-to-low change of `fall_i[c]` advances channel c by one when the previous synchronized sample of `rise_i[c]` is low.
- R3: A rise of `rise_i` while `fall_i` is low does not count. A fall of `fall_i` while `rise_i` is high does not count. A fall of `rise_i` and a rise of `fall_i` never count.
- R4: When a qualified rise and a qualified fall are detected in the same clock cycle, the count advances by one, not two.
- R5: The count never exceeds 9. The next count after 9 is 0, and bit 3 of the count falls at that point.
- R6: Raising `clear_i[c]` forces `count_o[4c+3:4c]` to 0 immediately, without waiting for a clock edge.
- R7: Edges that arrive while clear is high are ignored, and the count stays 0 after release. Counting resumes after release, once a hold of 3 clock cycles has passed.
- R8: The channels are independent: control activity or a clear on one channel leaves the other channel's count unchanged.
- R9: A control change made between clock edges first shows on `count_o` after the third rising clock edge that follows it.
- R10: Driving channel 1's `fall_i` from bit 3 of channel 0, with `rise_i[1]` low, forms a 00 to 99 counter that returns to 00 after 100 counts.
- R11: With `rst_ni` low, all counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| rise_i | input | NUM_CH | Count line active on its rising edge, one per channel |
| fall_i | input | NUM_CH | Count line active on its falling edge, one per channel |
| clear_i | input | NUM_CH | Active-high asynchronous clear, one per channel |
| count_o | output | 4*NUM_CH | BCD count, channel c in bits 4c+3..4c |

## Verification
A vector table steps one channel through every pairing of the two control lines. The table separates a true edge from one blocked by the other line, and also separates the inactive edge directions from the active ones. It also includes a simultaneous rise and fall, which reveals any double counting. Directed runs then check the 9-to-0 wrap, the exact three-edge latency, and an asynchronous clear in mid-count with an edge hidden inside it. A full 100-count chained run shows that the wrap edge of bit 3 carries cleanly into the tens digit.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int unsigned DIGIT_W   = 4;
  localparam int unsigned DIGIT_MAX = 9;
  localparam int unsigned SYNC_LEN  = 2;
  localparam int unsigned HOLD_LEN  = 3;
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/ddc_sync.sv
module ddc_sync #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned DEPTH = ddc_pkg::SYNC_LEN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/ddc_edge_qual.sv
module ddc_edge_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_s_i,
  input  logic fall_s_i,
  output logic step_o
);
  logic rise_p_q, fall_p_q;
  logic rise_ev, fall_ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_p_q <= 1'b0;
      fall_p_q <= 1'b0;
    end else begin
      rise_p_q <= rise_s_i;
      fall_p_q <= fall_s_i;
    end
  end

  // qualifier is the other line's level before this edge
  assign rise_ev = rise_s_i & ~rise_p_q & fall_p_q;
  assign fall_ev = ~fall_s_i & fall_p_q & ~rise_p_q;
  assign step_o  = rise_ev | fall_ev;  // merge: one count per cycle

  p_gate_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall_p_q && !(fall_p_q && !fall_s_i)) |-> !step_o);
endmodule

// File: rtl/ddc_digit.sv
module ddc_digit
  import ddc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clear_i,
  input  logic   step_i,
  output digit_t count_o
);
  logic [HOLD_LEN-1:0] hold_q;
  digit_t cnt_q;
  logic hold;

  always_ff @(posedge clk_i or negedge rst_ni or posedge clear_i) begin
    if (!rst_ni)      hold_q <= '1;
    else if (clear_i) hold_q <= '1;
    else              hold_q <= {hold_q[HOLD_LEN-2:0], 1'b0};
  end

  assign hold = hold_q[HOLD_LEN-1];

  always_ff @(posedge clk_i or negedge rst_ni or posedge clear_i) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (step_i && !hold)   cnt_q <= (cnt_q == digit_t'(DIGIT_MAX)) ? '0 : cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  p_bcd_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= digit_t'(DIGIT_MAX));
  p_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (step_i && !hold && cnt_q == digit_t'(DIGIT_MAX)) |=> cnt_q == '0);
  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (step_i && !hold && cnt_q != digit_t'(DIGIT_MAX)) |=> cnt_q == $past(cnt_q) + 1'b1);
  p_no_double_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    !(step_i && !hold) |=> $stable(cnt_q));
  p_clear_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |-> cnt_q == '0);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    hold |=> cnt_q == '0);
endmodule

// File: rtl/ddc_channel.sv
module ddc_channel
  import ddc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   rise_i,
  input  logic   fall_i,
  input  logic   clear_i,
  output digit_t count_o
);
  logic [1:0] lines_s;
  logic step;

  ddc_sync #(.WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({fall_i, rise_i}),
    .q_o   (lines_s)
  );

  ddc_edge_qual u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_s_i(lines_s[0]),
    .fall_s_i(lines_s[1]),
    .step_o  (step)
  );

  ddc_digit u_digit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .step_i (step),
    .count_o(count_o)
  );
endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_CH-1:0]                   rise_i,
  input  logic [NUM_CH-1:0]                   fall_i,
  input  logic [NUM_CH-1:0]                   clear_i,
  output logic [NUM_CH*ddc_pkg::DIGIT_W-1:0]  count_o
);
  localparam int unsigned DW = ddc_pkg::DIGIT_W;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ddc_channel u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rise_i (rise_i[c]),
      .fall_i (fall_i[c]),
      .clear_i(clear_i[c]),
      .count_o(count_o[c*DW +: DW])
    );
  end
endmodule

// File: tb/dual_decade_counter_tb.sv
module dual_decade_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rise_d = 2'b00;
  logic [1:0] fall_d = 2'b11;
  logic [1:0] clr_d = 2'b00;
  logic cascade = 1'b0;
  logic [1:0] fall_w;
  logic [7:0] cnt;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign fall_w = {cascade ? cnt[3] : fall_d[1], fall_d[0]};

  dual_decade_counter dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .rise_i (rise_d),
    .fall_i (fall_w),
    .clear_i(clr_d),
    .count_o(cnt)
  );

  // {rise, fall, expected count of channel 0}
  localparam logic [5:0] VEC [12] = '{
    {2'b11, 4'd1},  // R1 rise, fall high
    {2'b01, 4'd1},  // R3 rise line falls
    {2'b00, 4'd2},  // R2 fall, rise low
    {2'b01, 4'd2},  // R3 fall line rises
    {2'b11, 4'd3},  // R1
    {2'b10, 4'd3},  // R3 fall while rise high
    {2'b00, 4'd3},
    {2'b10, 4'd3},  // R3 rise while fall low
    {2'b00, 4'd3},
    {2'b01, 4'd3},
    {2'b10, 4'd4},  // R4 both edges together
    {2'b01, 4'd4}
  };

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse0();
    rise_d[0] = 1'b1; wait_n(4);
    rise_d[0] = 1'b0; wait_n(4);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    check("R11 reset", cnt, 0);
    rst_n = 1'b1;
    wait_n(6);

    for (int i = 0; i < 12; i++) begin
      rise_d[0] = VEC[i][5];
      fall_d[0] = VEC[i][4];
      wait_n(4);
      check($sformatf("R1/R2/R3/R4 vec %0d", i), cnt[3:0], VEC[i][3:0]);
    end

    // R5 wrap
    for (int i = 0; i < 5; i++) pulse0();
    check("R5 reach 9", cnt[3:0], 9);
    pulse0();
    check("R5 wrap to 0", cnt[3:0], 0);

    // R9 latency
    rise_d[0] = 1'b1;
    wait_n(2);
    check("R9 before 3rd edge", cnt[3:0], 0);
    wait_n(1);
    check("R9 at 3rd edge", cnt[3:0], 1);
    rise_d[0] = 1'b0; wait_n(4);

    // R8 independence
    check("R8 ch1 idle", cnt[7:4], 0);
    fall_d[1] = 1'b0; wait_n(4);
    check("R2 ch1 count", cnt[7:4], 1);
    check("R8 ch0 untouched", cnt[3:0], 1);

    // R6/R7 clear mid-count
    pulse0();
    check("R1 before clear", cnt[3:0], 2);
    #5 clr_d[0] = 1'b1;
    #1 check("R6 async clear", cnt[3:0], 0);
    check("R8 ch1 kept on clear", cnt[7:4], 1);
    wait_n(1);
    rise_d[0] = 1'b1; wait_n(6);
    clr_d[0] = 1'b0; wait_n(6);
    check("R7 edge in clear ignored", cnt[3:0], 0);
    rise_d[0] = 1'b0; wait_n(4);
    pulse0();
    check("R7 resume", cnt[3:0], 1);

    // R11 + R10 cascade
    rst_n = 1'b0;
    wait_n(1);
    check("R11 reset mid-run", cnt, 0);
    rise_d = 2'b00;
    fall_d = 2'b11;
    cascade = 1'b1;
    wait_n(1);
    rst_n = 1'b1;
    wait_n(6);
    for (int i = 1; i <= 100; i++) begin
      pulse0();
      if (i % 25 == 0 || i == 10 || i == 99)
        check($sformatf("R10 cascade %0d", i), cnt[7:4] * 10 + cnt[3:0], i % 100);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule